// File: doc/BRIEF.md
# NAND Bus Transaction Monitor

A passive observer for an asynchronous 8-bit NAND flash interface. It samples the chip enable, the two latch enables, the write and read strobes, the ready/busy line and the data bus. It never drives any of them. Every strobe edge that falls inside a chip-enabled window becomes one tagged record. A record is a command, an address, a written byte, a byte read back, a protocol error, or the start or end of a busy period. Each record carries the cycle count at which the edge was seen.

All bus pins pass through a two-flop synchroniser. The monitor clock must run at least four times faster than the fastest strobe. Edges are found on the synchronised copies, so a record reaches the stream a few clock cycles after the pin event.

Records leave through a valid/ready stream backed by a small FIFO.
- Back-pressure is allowed at any time. While `out_ready` is low, the head record stays on the outputs unchanged.
- A record leaves the FIFO on every cycle in which `out_valid` and `out_ready` are both high.
- If a record arrives while the FIFO is full, the new record is discarded. The sticky `overflow` flag is then set and stays set until reset.

Top module: `nand_bus_monitor`

## Requirements
- R1: With chip enable low, command latch high and address latch low, a rising write strobe yields a record with `out_status`=0, `out_kind`=0 and `out_value` equal to the bus byte.
- R2: With chip enable low, address latch high and command latch low, a rising write strobe yields `out_status`=0, `out_kind`=1 and the bus byte.
- R3: With chip enable low and both latch enables low, a rising write strobe yields `out_status`=0, `out_kind`=2 and the bus byte.
- R4: With chip enable low, a rising read strobe yields `out_status`=0, `out_kind`=3 and the bus byte.
- R5: While chip enable is high, write and read strobe edges produce no record.
- R6: A rising write strobe with both latch enables high yields a status record: `out_status`=1, `out_kind`=2 and the bus byte.
- R7: A command record carries `out_mark`=1 for opcode 0xFF and `out_mark`=2 for opcode 0x90; all other records carry 0. Opcode 0x90 is marked even when no 0xFF was seen before it.
- R8: A falling ready/busy line yields a status record with `out_kind`=0. A rising one yields a status record with `out_kind`=1.
- R9: The `out_stamp` values of two records differ by exactly the number of clock cycles between the pin events that caused them.
- R10: While `out_valid` is high and `out_ready` is low, the record on the outputs is held stable. Records leave in arrival order, one per cycle in which valid and ready are both high.
- R11: A record that arrives while the FIFO holds FIFO_DEPTH entries is dropped. `overflow` then goes high and stays high until reset.
- R12: After reset, `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, at least 4x the fastest strobe rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| nand_ce_n | input | 1 | Chip enable, active low |
| nand_cle | input | 1 | Command latch enable, active high |
| nand_ale | input | 1 | Address latch enable, active high |
| nand_we_n | input | 1 | Write strobe, active low |
| nand_re_n | input | 1 | Read strobe, active low |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| nand_data | input | 8 | Bidirectional bus, observed only |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts record |
| out_status | output | 1 | 1 = status record (busy edge or protocol error) |
| out_kind | output | 2 | Byte class, or status code when out_status is 1 |
| out_mark | output | 2 | Opcode mark: 1 reset opcode, 2 read-ID opcode |
| out_value | output | 8 | Captured byte |
| out_stamp | output | 32 | Cycle count at detection |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
Each kind of internal fault shows up at the stream outputs within a few cycles.
- Wrong strobe edge polarity or wrong latch decoding gives the wrong kind code. This appears within about four cycles of the strobe release.
- A lost busy edge means an expected status record never appears.
- A wrong timestamp or a synchroniser path of uneven length changes the stamp difference between two busy records taken a known distance apart.
- Broken FIFO pointers show up as out-of-order or repeated values when a burst is drained.
- A wrong full test shows up as `overflow` rising either too early or never.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  localparam int STAMP_W = 32;

  localparam logic [1:0] K_CMD   = 2'd0;
  localparam logic [1:0] K_ADDR  = 2'd1;
  localparam logic [1:0] K_WDATA = 2'd2;
  localparam logic [1:0] K_RDATA = 2'd3;

  localparam logic [1:0] S_BUSY_ON  = 2'd0;
  localparam logic [1:0] S_BUSY_OFF = 2'd1;
  localparam logic [1:0] S_PROTO    = 2'd2;

  localparam logic [1:0] M_NONE  = 2'd0;
  localparam logic [1:0] M_RESET = 2'd1;
  localparam logic [1:0] M_RDID  = 2'd2;

  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] OP_RDID  = 8'h90;

  typedef struct packed {
    logic               status;
    logic [1:0]         kind;
    logic [1:0]         mark;
    logic [7:0]         value;
    logic [STAMP_W-1:0] stamp;
  } rec_t;
endpackage

// File: rtl/nbm_sync.sv
module nbm_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/nbm_classify.sv
module nbm_classify
  import nbm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               we_n,
  input  logic               re_n,
  input  logic               rb,
  input  logic [7:0]         data,
  input  logic [STAMP_W-1:0] stamp,
  output logic               ev_valid,
  output rec_t               ev_rec
);
  logic we_d, re_d, rb_d;
  logic we_rise, re_rise, rb_edge, bus_hit;
  logic pend_v;
  rec_t pend_rec, bus_rec, rb_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
      rb_d <= 1'b1;
    end else begin
      we_d <= we_n;
      re_d <= re_n;
      rb_d <= rb;
    end
  end

  assign we_rise = we_n & ~we_d;
  assign re_rise = re_n & ~re_d;
  assign rb_edge = rb ^ rb_d;
  assign bus_hit = ~ce_n & (we_rise | re_rise);

  always_comb begin
    bus_rec        = '0;
    bus_rec.value  = data;
    bus_rec.stamp  = stamp;
    bus_rec.mark   = M_NONE;
    if (we_rise) begin
      if (cle && ale) begin
        bus_rec.status = 1'b1;
        bus_rec.kind   = S_PROTO;
      end else if (cle) begin
        bus_rec.kind = K_CMD;
        if (data == OP_RESET)     bus_rec.mark = M_RESET;
        else if (data == OP_RDID) bus_rec.mark = M_RDID;
      end else if (ale) begin
        bus_rec.kind = K_ADDR;
      end else begin
        bus_rec.kind = K_WDATA;
      end
    end else begin
      bus_rec.kind = K_RDATA;
    end
  end

  always_comb begin
    rb_rec        = '0;
    rb_rec.status = 1'b1;
    rb_rec.kind   = rb ? S_BUSY_OFF : S_BUSY_ON;
    rb_rec.stamp  = stamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_rec   <= '0;
      pend_v   <= 1'b0;
      pend_rec <= '0;
    end else begin
      if (bus_hit) begin
        ev_valid <= 1'b1;
        ev_rec   <= bus_rec;
        if (rb_edge) begin
          pend_v   <= 1'b1;
          pend_rec <= rb_rec;
        end
      end else if (pend_v) begin
        ev_valid <= 1'b1;
        ev_rec   <= pend_rec;
        pend_v   <= rb_edge;
        if (rb_edge) pend_rec <= rb_rec;
      end else if (rb_edge) begin
        ev_valid <= 1'b1;
        ev_rec   <= rb_rec;
      end else begin
        ev_valid <= 1'b0;
      end
    end
  end

  // R5
  ce_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && (we_rise || re_rise)) |=> !(ev_valid && !ev_rec.status));

  // R8
  busy_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_edge |=> ev_valid);

  // R7
  reset_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_rec.mark == M_RESET) |->
      (ev_rec.value == OP_RESET && !ev_rec.status && ev_rec.kind == K_CMD));
endmodule

// File: rtl/nbm_fifo.sv
module nbm_fifo
  import nbm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  rec_t wr_rec,
  output logic rd_valid,
  input  logic rd_ready,
  output rec_t rd_rec,
  output logic overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rec_t          mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, push, pop;

  assign full     = (cnt == CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign push     = wr_valid && !full;
  assign pop      = rd_valid && rd_ready;
  assign rd_rec   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr_valid && full) overflow <= 1'b1;
    end
  end

  // R10
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_rec)));

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full) |=> overflow);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/nand_bus_monitor.sv
module nand_bus_monitor
  import nbm_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nand_ce_n,
  input  logic               nand_cle,
  input  logic               nand_ale,
  input  logic               nand_we_n,
  input  logic               nand_re_n,
  input  logic               nand_rb,
  input  logic [7:0]         nand_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_status,
  output logic [1:0]         out_kind,
  output logic [1:0]         out_mark,
  output logic [7:0]         out_value,
  output logic [STAMP_W-1:0] out_stamp,
  output logic               overflow
);
  localparam int BUS_W = 14;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00};

  logic [BUS_W-1:0]   bus_s;
  logic [STAMP_W-1:0] stamp_q;
  logic               ev_valid;
  rec_t               ev_rec, head;

  nbm_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .INIT(BUS_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_rb, nand_data}),
    .q     (bus_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else        stamp_q <= stamp_q + 1'b1;
  end

  nbm_classify u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (bus_s[13]),
    .cle      (bus_s[12]),
    .ale      (bus_s[11]),
    .we_n     (bus_s[10]),
    .re_n     (bus_s[9]),
    .rb       (bus_s[8]),
    .data     (bus_s[7:0]),
    .stamp    (stamp_q),
    .ev_valid (ev_valid),
    .ev_rec   (ev_rec)
  );

  nbm_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (ev_valid),
    .wr_rec   (ev_rec),
    .rd_valid (out_valid),
    .rd_ready (out_ready),
    .rd_rec   (head),
    .overflow (overflow)
  );

  assign out_status = head.status;
  assign out_kind   = head.kind;
  assign out_mark   = head.mark;
  assign out_value  = head.value;
  assign out_stamp  = head.stamp;
endmodule

// File: tb/sim_nand_bus_monitor.sv
module sim_nand_bus_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, rb = 1'b1;
  logic [7:0] data = 8'h00;
  logic out_ready = 1'b0;
  logic out_valid, out_status, overflow;
  logic [1:0] out_kind, out_mark;
  logic [7:0] out_value;
  logic [31:0] out_stamp;
  int checks = 0, fails = 0;
  logic [31:0] t0;

  always #2 clk = ~clk;

  nand_bus_monitor u0 (
    .clk(clk), .rst_n(rst_n), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_rb(rb), .nand_data(data),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
    .out_kind(out_kind), .out_mark(out_mark), .out_value(out_value),
    .out_stamp(out_stamp), .overflow(overflow)
  );

  typedef struct packed {
    logic       rd;
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic [7:0] val;
    logic       ev;
    logic       st;
    logic [1:0] kind;
    logic [1:0] mark;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h90, 1'b1, 1'b0, 2'd0, 2'd2},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 2'd1, 2'd0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h98, 1'b1, 1'b0, 2'd3, 2'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 2'd0, 2'd1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h70, 1'b1, 1'b0, 2'd0, 2'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b0, 2'd2, 2'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 1'b1, 1'b1, 2'd2, 2'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 2'd1, 2'd0}
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R7";
      1: return "R2";
      2: return "R4";
      3: return "R7";
      4: return "R1";
      5: return "R3";
      6: return "R6";
      7: return "R5";
      8: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit rd, input bit c_n, input bit cl, input bit al, input logic [7:0] v);
    @(negedge clk);
    ce_n = c_n; cle = cl; ale = al; data = v;
    @(negedge clk);
    if (rd) re_n = 1'b0; else we_n = 1'b0;
    repeat (3) @(negedge clk);
    re_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 1'b0, "R12", out_valid, 0);
    check(overflow == 1'b0, "R12", overflow, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R12", out_valid, 0);

    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i].rd, VECS[i].ce_n, VECS[i].cle, VECS[i].ale, VECS[i].val);
      if (VECS[i].ev) begin
        check(out_valid == 1'b1, req_of(i), out_valid, 1);
        check({out_status, out_kind, out_mark, out_value} ==
              {VECS[i].st, VECS[i].kind, VECS[i].mark, VECS[i].val}, req_of(i),
              {out_status, out_kind, out_mark, out_value},
              {VECS[i].st, VECS[i].kind, VECS[i].mark, VECS[i].val});
        pop();
      end else begin
        check(out_valid == 1'b0, req_of(i), out_valid, 0);
      end
    end

    // R8 and R9: busy interval of exactly 20 cycles
    @(negedge clk); rb = 1'b0;
    repeat (20) @(negedge clk);
    rb = 1'b1;
    repeat (8) @(negedge clk);
    check(out_valid && out_status && out_kind == 2'd0, "R8", {out_status, out_kind}, 3'b100);
    t0 = out_stamp;
    // R10: head held while not ready
    repeat (3) @(negedge clk);
    check(out_valid && out_stamp == t0 && out_kind == 2'd0, "R10", out_stamp, t0);
    pop();
    check(out_valid && out_status && out_kind == 2'd1, "R8", {out_status, out_kind}, 3'b101);
    check(out_stamp - t0 == 32'd20, "R9", out_stamp - t0, 20);
    pop();
    check(out_valid == 1'b0, "R10", out_valid, 0);

    // R11: five records into a four-entry FIFO
    for (int k = 1; k <= 5; k++) strobe(1'b0, 1'b0, 1'b1, 1'b0, 8'(k));
    check(overflow == 1'b1, "R11", overflow, 1);
    for (int k = 1; k <= 4; k++) begin
      check(out_valid && out_value == 8'(k), "R11", out_value, k);
      pop();
    end
    check(out_valid == 1'b0, "R11", out_valid, 0);
    repeat (5) @(negedge clk);
    check(overflow == 1'b1, "R11", overflow, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule